// File: doc/BRIEF.md
# Selectable Polynomial Noise Source

This block supplies the pseudo-random bit streams for a sound generator that has three tone channels and one noise channel. It keeps seven maximal-length shift registers of 4, 5, 7, 9, 11, 15 and 17 bits. A five-bit control word decides which register feeds which channel group and how fast each register advances. In normal operation the tone channels draw on the short 7-bit register, and the noise channel draws on a long register of selectable length. When the swap bit is set the two groups trade sources, and each source also moves to the other group's clock.

Everything runs on one system clock and advances only on single-cycle enable strobes. There is a fast strobe (the 250 kHz step rate), a fixed noise-rate strobe (31.25 kHz), and one output-rate strobe per tone channel. A hold bit per tone channel freezes that channel. An oscillator reset pulse puts every register back to its seed and clears every output bit.

Top module: `pn_source`

## Requirements
- R1: After the synchronous reset `rst`, all three tone outputs and the noise output are 0, and every shift register holds all ones.
- R2: Each tone channel has a two-bit source code in `tone_src[2i+1:2i]`. Code 0 selects the 4-bit register, 1 selects the 5-bit register, 2 selects the shared slot, and 3 forces that channel's output to 0 at its strobe.
- R3: With `ctrl[4]`=0 the shared slot carries the 7-bit register, which steps on `stb_fast`. The noise channel carries the long register chosen by `ctrl[3:2]` (0: 17 bits, 1: 15 bits, 2: 11 bits, 3: 9 bits), and that register steps on the noise clock.
- R4: With `ctrl[4]`=1 the shared slot carries the chosen long register, which now steps on `stb_fast`. The noise channel carries the 7-bit register, which now steps on the noise clock.
- R5: The noise clock is chosen by `ctrl[1:0]`. Code 0 selects `stb_noise_base`, and codes 1, 2 and 3 select the enabled strobe of tone channel 0, 1 or 2. The 4-bit and 5-bit registers always step on `stb_fast`.
- R6: Each register shifts left. The new LSB is the XOR of bit N and bit T, counted from 1, with T equal to 3, 3, 6, 5, 9, 14 and 14 for N = 4, 5, 7, 9, 11, 15 and 17. The output bit is the MSB. When stepped on every cycle, each stream repeats with period 2^N-1. A register that holds all zeros reloads all ones.
- R7: A cycle with `osc_rst` high reloads every register with all ones and clears all outputs on the next edge. This takes priority over any strobe.
- R8: While `sync_hold[i]` is high, tone output i keeps its value, and that channel's strobe also stops clocking the noise channel.
- R9: At each enabled strobe an output register takes the MSB its current selection points to, read before that edge's step. A change of source or control bits therefore shows up at the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl | input | 5 | Swap bit [4], long length [3:2], noise clock select [1:0] |
| tone_src | input | 6 | Two-bit source code per tone channel |
| stb_fast | input | 1 | Fast step enable (250 kHz rate) |
| stb_noise_base | input | 1 | Fixed noise-rate enable (31.25 kHz rate) |
| stb_tone | input | 3 | Output-rate enable of each tone channel |
| sync_hold | input | 3 | Per-channel hold |
| osc_rst | input | 1 | Oscillator reset command pulse |
| tone_pn | output | 3 | PN bit per tone channel |
| noise_pn | output | 1 | PN bit of the noise channel |

## Verification
The assertions take for granted that every strobe lasts a single cycle when seen by the block. They also assume that `ctrl`, `tone_src` and `sync_hold` are plain levels sampled at each edge, with no meaning attached to how long they are held. The stimulus changes these inputs only on the falling clock edge, so each rising edge sees values that are settled. The stimulus keeps `osc_rst` to isolated one-cycle pulses, except during the period runs, where every strobe is held high on purpose so that each register steps on every cycle.

// File: rtl/pnsrc_pkg.sv
package pnsrc_pkg;

    localparam int unsigned NUM_TONE = 3;
    localparam int unsigned NUM_PN   = 7;
    localparam int unsigned IDX_PN7  = 2;

    typedef enum logic [1:0] {
        SRC_PN4  = 2'd0,
        SRC_PN5  = 2'd1,
        SRC_SLOT = 2'd2,
        SRC_OFF  = 2'd3
    } tone_src_e;

    typedef enum logic [1:0] {
        LEN_17 = 2'd0,
        LEN_15 = 2'd1,
        LEN_11 = 2'd2,
        LEN_9  = 2'd3
    } long_len_e;

    typedef struct packed {
        logic      swap;
        long_len_e len;
        logic [1:0] nclk_sel;
    } ctrl_t;

    // register widths, ascending; slots 0..2 are the short ones
    function automatic int pn_width(input int idx);
        case (idx)
            0: return 4;
            1: return 5;
            2: return 7;
            3: return 9;
            4: return 11;
            5: return 15;
            default: return 17;
        endcase
    endfunction

    // second feedback tap (1-based) for a maximal sequence
    function automatic int pn_tap(input int idx);
        case (idx)
            0: return 3;
            1: return 3;
            2: return 6;
            3: return 5;
            4: return 9;
            5: return 14;
            default: return 14;
        endcase
    endfunction

    function automatic int long_idx(input long_len_e len);
        case (len)
            LEN_17: return 6;
            LEN_15: return 5;
            LEN_11: return 4;
            default: return 3;
        endcase
    endfunction

endpackage

// File: rtl/pn_lfsr.sv
module pn_lfsr #(
    parameter int W = 7,
    parameter int T = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic reseed,
    input  logic step,
    output logic msb
);
    localparam logic [W-1:0] SEED = {W{1'b1}};

    logic [W-1:0] state;
    logic         fb;

    assign fb  = state[W-1] ^ state[T-1];
    assign msb = state[W-1];

    always_ff @(posedge clk) begin
        if (rst || reseed) begin
            state <= SEED;
        end else if (state == '0) begin
            state <= SEED;
        end else if (step) begin
            state <= {state[W-2:0], fb};
        end
    end
endmodule

// File: rtl/pn_bank.sv
module pn_bank
    import pnsrc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reseed,
    input  logic              step_short,
    input  logic              step_mid,
    input  logic              step_long,
    output logic [NUM_PN-1:0] msb
);
    for (genvar g = 0; g < NUM_PN; g++) begin : g_pn
        logic step_g;
        if (g < IDX_PN7) begin : g_short
            assign step_g = step_short;
        end else if (g == IDX_PN7) begin : g_mid
            assign step_g = step_mid;
        end else begin : g_long
            assign step_g = step_long;
        end

        pn_lfsr #(
            .W(pn_width(g)),
            .T(pn_tap(g))
        ) u_lfsr (
            .clk   (clk),
            .rst   (rst),
            .reseed(reseed),
            .step  (step_g),
            .msb   (msb[g])
        );
    end
endmodule

// File: rtl/pn_clksel.sv
module pn_clksel
    import pnsrc_pkg::*;
(
    input  ctrl_t               ctrl,
    input  logic                stb_fast,
    input  logic                stb_noise_base,
    input  logic [NUM_TONE-1:0] stb_tone,
    input  logic [NUM_TONE-1:0] sync_hold,
    output logic [NUM_TONE-1:0] tone_en,
    output logic                noise_clk,
    output logic                step_short,
    output logic                step_mid,
    output logic                step_long
);
    assign tone_en = stb_tone & ~sync_hold;

    always_comb begin
        case (ctrl.nclk_sel)
            2'd0:    noise_clk = stb_noise_base;
            2'd1:    noise_clk = tone_en[0];
            2'd2:    noise_clk = tone_en[1];
            default: noise_clk = tone_en[2];
        endcase
    end

    assign step_short = stb_fast;
    assign step_mid   = ctrl.swap ? noise_clk : stb_fast;
    assign step_long  = ctrl.swap ? stb_fast  : noise_clk;
endmodule

// File: rtl/pn_router.sv
module pn_router
    import pnsrc_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  osc_rst,
    input  ctrl_t                 ctrl,
    input  logic [2*NUM_TONE-1:0] tone_src,
    input  logic [NUM_TONE-1:0]   tone_en,
    input  logic                  noise_clk,
    input  logic [NUM_PN-1:0]     msb,
    output logic [NUM_TONE-1:0]   tone_pn,
    output logic                  noise_pn
);
    logic long_bit;
    logic slot_bit;
    logic noise_src;

    assign long_bit  = msb[long_idx(ctrl.len)];
    assign slot_bit  = ctrl.swap ? long_bit     : msb[IDX_PN7];
    assign noise_src = ctrl.swap ? msb[IDX_PN7] : long_bit;

    always_ff @(posedge clk) begin
        if (rst || osc_rst) begin
            tone_pn  <= '0;
            noise_pn <= 1'b0;
        end else begin
            for (int i = 0; i < NUM_TONE; i++) begin
                if (tone_en[i]) begin
                    case (tone_src_e'(tone_src[2*i +: 2]))
                        SRC_PN4:  tone_pn[i] <= msb[0];
                        SRC_PN5:  tone_pn[i] <= msb[1];
                        SRC_SLOT: tone_pn[i] <= slot_bit;
                        default:  tone_pn[i] <= 1'b0;
                    endcase
                end
            end
            if (noise_clk) begin
                noise_pn <= noise_src;
            end
        end
    end
endmodule

// File: rtl/pn_source.sv
module pn_source
    import pnsrc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [4:0] ctrl,
    input  logic [5:0] tone_src,
    input  logic       stb_fast,
    input  logic       stb_noise_base,
    input  logic [2:0] stb_tone,
    input  logic [2:0] sync_hold,
    input  logic       osc_rst,
    output logic [2:0] tone_pn,
    output logic       noise_pn
);
    ctrl_t              ctrl_s;
    logic [NUM_TONE-1:0] tone_en;
    logic               noise_clk;
    logic               step_short;
    logic               step_mid;
    logic               step_long;
    logic [NUM_PN-1:0]  msb;

    assign ctrl_s = ctrl_t'(ctrl);

    pn_clksel u_clksel (
        .ctrl          (ctrl_s),
        .stb_fast      (stb_fast),
        .stb_noise_base(stb_noise_base),
        .stb_tone      (stb_tone),
        .sync_hold     (sync_hold),
        .tone_en       (tone_en),
        .noise_clk     (noise_clk),
        .step_short    (step_short),
        .step_mid      (step_mid),
        .step_long     (step_long)
    );

    pn_bank u_bank (
        .clk       (clk),
        .rst       (rst),
        .reseed    (osc_rst),
        .step_short(step_short),
        .step_mid  (step_mid),
        .step_long (step_long),
        .msb       (msb)
    );

    pn_router u_router (
        .clk      (clk),
        .rst      (rst),
        .osc_rst  (osc_rst),
        .ctrl     (ctrl_s),
        .tone_src (tone_src),
        .tone_en  (tone_en),
        .noise_clk(noise_clk),
        .msb      (msb),
        .tone_pn  (tone_pn),
        .noise_pn (noise_pn)
    );
endmodule

// File: rtl/pn_source_chk.sv
module pn_source_chk (
    input logic       clk,
    input logic       rst,
    input logic [4:0] ctrl,
    input logic [5:0] tone_src,
    input logic       stb_noise_base,
    input logic [2:0] stb_tone,
    input logic [2:0] sync_hold,
    input logic       osc_rst,
    input logic [2:0] tone_pn,
    input logic       noise_pn
);
    logic [2:0] en_c;
    logic       nclk_c;

    assign en_c   = stb_tone & ~sync_hold;
    assign nclk_c = (ctrl[1:0] == 2'd0) ? stb_noise_base : en_c[ctrl[1:0] - 2'd1];

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (tone_pn == 3'b000 && noise_pn == 1'b0)); // R1

    AST_OSC_CLEAR: assert property (@(posedge clk) disable iff (rst)
        osc_rst |=> (tone_pn == 3'b000 && noise_pn == 1'b0)); // R7

    AST_NOISE_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!osc_rst && !nclk_c) |=> $stable(noise_pn)); // R5

    for (genvar i = 0; i < 3; i++) begin : g_ch
        AST_SYNC_HOLD: assert property (@(posedge clk) disable iff (rst)
            (sync_hold[i] && !osc_rst) |=> $stable(tone_pn[i])); // R8

        AST_OFF_CODE: assert property (@(posedge clk) disable iff (rst)
            (en_c[i] && tone_src[2*i +: 2] == 2'd3) |=> !tone_pn[i]); // R2
    end
endmodule

bind pn_source pn_source_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .ctrl          (ctrl),
    .tone_src      (tone_src),
    .stb_noise_base(stb_noise_base),
    .stb_tone      (stb_tone),
    .sync_hold     (sync_hold),
    .osc_rst       (osc_rst),
    .tone_pn       (tone_pn),
    .noise_pn      (noise_pn)
);

// File: tb/pn_source_bench.sv
module pn_source_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] ctrl = '0;
    logic [5:0] tone_src = '0;
    logic       stb_fast = 1'b0;
    logic       stb_noise_base = 1'b0;
    logic [2:0] stb_tone = '0;
    logic [2:0] sync_hold = '0;
    logic       osc_rst = 1'b0;
    logic [2:0] tone_pn;
    logic       noise_pn;

    int n_checks = 0;
    int n_fail   = 0;
    bit cmp_en   = 1'b0;
    string phase = "R1";

    always #10 clk = ~clk;

    pn_source u_pn_source (
        .clk(clk), .rst(rst), .ctrl(ctrl), .tone_src(tone_src),
        .stb_fast(stb_fast), .stb_noise_base(stb_noise_base),
        .stb_tone(stb_tone), .sync_hold(sync_hold), .osc_rst(osc_rst),
        .tone_pn(tone_pn), .noise_pn(noise_pn)
    );

    // behavioural reference: widths, taps and state as plain integers
    int wid[7] = '{4, 5, 7, 9, 11, 15, 17};
    int tap[7] = '{3, 3, 6, 5, 9, 14, 14};
    int st[7];
    bit exp_tone[3];
    bit exp_noise;

    function automatic bit top_bit(int k);
        return bit'((st[k] >> (wid[k] - 1)) & 1);
    endfunction

    function automatic int advance(int k);
        int nb;
        nb = ((st[k] >> (wid[k] - 1)) ^ (st[k] >> (tap[k] - 1))) & 1;
        return ((st[k] << 1) | nb) & ((1 << wid[k]) - 1);
    endfunction

    always @(posedge clk) begin
        if (rst || osc_rst) begin
            for (int k = 0; k < 7; k++) st[k] = (1 << wid[k]) - 1;
            for (int i = 0; i < 3; i++) exp_tone[i] = 1'b0;
            exp_noise = 1'b0;
        end else begin
            bit en[3];
            bit nclk;
            int lk;
            bit slot;
            bit nsrc;
            bit stepk[7];
            for (int i = 0; i < 3; i++) en[i] = stb_tone[i] && !sync_hold[i];
            nclk = (ctrl[1:0] == 0) ? stb_noise_base : en[ctrl[1:0] - 1];
            lk   = 6 - int'(ctrl[3:2]);
            slot = ctrl[4] ? top_bit(lk) : top_bit(2);
            nsrc = ctrl[4] ? top_bit(2) : top_bit(lk);
            for (int i = 0; i < 3; i++) begin
                if (en[i]) begin
                    case (tone_src[2*i +: 2])
                        2'd0: exp_tone[i] = top_bit(0);
                        2'd1: exp_tone[i] = top_bit(1);
                        2'd2: exp_tone[i] = slot;
                        default: exp_tone[i] = 1'b0;
                    endcase
                end
            end
            if (nclk) exp_noise = nsrc;
            stepk[0] = stb_fast;
            stepk[1] = stb_fast;
            stepk[2] = ctrl[4] ? nclk : stb_fast;
            for (int k = 3; k < 7; k++) stepk[k] = ctrl[4] ? stb_fast : nclk;
            for (int k = 0; k < 7; k++) if (stepk[k]) st[k] = advance(k);
        end
    end

    task automatic check(bit ok, string tag, int act, int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_en) begin
            int e;
            e = {exp_noise, exp_tone[2], exp_tone[1], exp_tone[0]};
            check({noise_pn, tone_pn} == e[3:0], phase, {noise_pn, tone_pn}, e);
        end
    end

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (199000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        summary();
    end

    logic hist [0:131199];

    task automatic period_run(logic [1:0] code, logic [4:0] c, int p, string tag);
        int bad;
        ctrl = c;
        tone_src = {4'b0000, code};
        stb_fast = 1'b1; stb_noise_base = 1'b1; stb_tone = 3'b111; sync_hold = '0;
        osc_rst = 1'b1;
        @(negedge clk);
        osc_rst = 1'b0;
        for (int n = 0; n < p + 20; n++) begin
            @(negedge clk);
            hist[n] = tone_pn[0];
        end
        bad = 0;
        for (int n = 0; n < 20; n++) if (hist[n] !== hist[n + p]) bad++;
        check(bad == 0, tag, bad, 0);
        bad = 0;
        for (int n = 0; n < 20; n++) if (hist[n] !== hist[n + 1]) bad++;
        check(bad != 0, tag, bad, 1);
    endtask

    initial begin
        logic held;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check({noise_pn, tone_pn} == 4'b0000, "R1 reset outputs", {noise_pn, tone_pn}, 0);
        cmp_en = 1'b1;

        // R3 R4 R5 R9: every control word under irregular strobes
        phase = "R3 R4 R5 R9 model";
        for (int c = 0; c < 32; c++) begin
            ctrl = c[4:0];
            tone_src = 6'($urandom);
            for (int n = 0; n < 40; n++) begin
                stb_fast = 1'($urandom);
                stb_noise_base = 1'($urandom);
                stb_tone = 3'($urandom);
                sync_hold = (($urandom % 8) == 0) ? 3'($urandom) : 3'b000;
                @(negedge clk);
            end
        end
        sync_hold = '0;

        // R9: length change takes effect on the next noise strobe
        phase = "R9 model";
        ctrl = 5'b0_00_00; stb_noise_base = 1'b0; stb_tone = '0;
        stb_fast = 1'b1;
        repeat (5) @(negedge clk);
        for (int c = 0; c < 4; c++) begin
            ctrl = {1'b0, 2'(c), 2'b00};
            @(negedge clk);
            stb_noise_base = 1'b1;
            @(negedge clk);
            stb_noise_base = 1'b0;
            repeat (2) @(negedge clk);
        end

        // R8: hold bit freezes channel 1 and its noise clocking
        phase = "R8 model";
        ctrl = 5'b0_00_10; tone_src = 6'b10_10_10;
        stb_fast = 1'b1; stb_tone = 3'b111; stb_noise_base = 1'b1;
        sync_hold = 3'b010;
        @(negedge clk);
        held = tone_pn[1];
        for (int n = 0; n < 30; n++) begin
            @(negedge clk);
            check(tone_pn[1] == held, "R8 hold tone1", tone_pn[1], held);
        end
        sync_hold = '0;

        // R2: code 3 gives 0
        phase = "R2 model";
        tone_src = 6'b11_00_01;
        repeat (2) @(negedge clk);
        for (int n = 0; n < 10; n++) begin
            check(tone_pn[2] == 1'b0, "R2 off code", tone_pn[2], 0);
            @(negedge clk);
        end

        // R7: oscillator reset clears outputs despite strobes
        phase = "R7 model";
        tone_src = 6'b10_01_00; ctrl = 5'b1_01_00;
        repeat (12) @(negedge clk);
        osc_rst = 1'b1;
        @(negedge clk);
        osc_rst = 1'b0;
        check({noise_pn, tone_pn} == 4'b0000, "R7 osc reset", {noise_pn, tone_pn}, 0);
        @(negedge clk);
        check(tone_pn[0] == 1'b1, "R7 seed ones pn4", tone_pn[0], 1);

        // R6: periods (R3 slot 7-bit, R4 slot long)
        phase = "R6 model";
        period_run(2'd0, 5'b0_00_00, 15,     "R6 period 4");
        period_run(2'd1, 5'b0_00_00, 31,     "R6 period 5");
        period_run(2'd2, 5'b0_00_00, 127,    "R6 R3 period 7");
        period_run(2'd2, 5'b1_11_00, 511,    "R6 R4 period 9");
        period_run(2'd2, 5'b1_10_00, 2047,   "R6 R4 period 11");
        period_run(2'd2, 5'b1_01_00, 32767,  "R6 R4 period 15");
        period_run(2'd2, 5'b1_00_00, 131071, "R6 R4 period 17");

        cmp_en = 1'b0;
        summary();
    end
endmodule